// File: doc/BRIEF.md
# PWM Tone and Volume Generator

This block produces audio from a single system clock. A prescaler counter wraps at a programmable count, and each wrap is one period of a fast pulse-width signal. A second counter counts those wraps and toggles a square-wave tone flip-flop each time it reaches its own programmed count. This gives a 50% duty tone whose pitch is set by both counters. The fast signal's duty cycle follows a volume setting, so it carries the amplitude.

Software writes four registers through a simple write strobe:
- a prescale value
- a pitch value
- a volume value
- a control word with a power bit and a composite-output bit

The three value registers are not used directly. Each is copied into a compare buffer only at the wrap of the counter that uses it, so a write never cuts a period short. With the composite bit set, the tone pin carries the tone ANDed with the PWM, which can drive a speaker stage directly.

Top module: `pwm_tone_gen`

## Requirements
- R1: After reset both outputs are low and every register reads as zero. Powering up with all-zero settings gives a tone that toggles on every clock and an amplitude output that stays low.
- R2: A write with `wr_sel`=0 sets the prescale value P from `wr_data[8:0]`, and 1 sets the pitch value T from `wr_data[5:0]`. A write with 2 sets the volume value V from `wr_data[8:0]`. A write with 3 sets power from bit 0 and composite mode from bit 1. All other data bits are ignored.
- R3: While powered, the prescaler wraps every P+1 clocks. `amp_o` rises at most once per wrap.
- R4: While powered, the tone toggles once every (P+1)*(T+1) clocks, giving a 50% duty square wave.
- R5: A write to the prescale, pitch or volume register changes nothing in the period in progress. It takes effect from the next wrap of the counter that uses it.
- R6: For 1 <= V <= P, `amp_o` is high for the first V clocks of every prescaler period and low for the rest.
- R7: With V = 0, `amp_o` stays low. With V > P, `amp_o` stays high.
- R8: With composite mode set, `tone_o` equals tone AND PWM, and `amp_o` still carries the PWM. With composite mode clear, `tone_o` carries the plain tone.
- R9: With power clear, the counters, the tone and the PWM are held at zero and both outputs are low. After power is set, the first prescaler period has `amp_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Register select (0 prescale, 1 pitch, 2 volume, 3 control) |
| wr_data | input | DATA_W | Write data |
| tone_o | output | 1 | Tone, or tone AND PWM in composite mode |
| amp_o | output | 1 | PWM amplitude signal |

## Verification
A wrong prescaler count or compare buffer shows up on `amp_o` within one prescaler period: the rising edges move or the high time changes. A fault in the pitch counter or the tone flip-flop shows up on `tone_o` within one tone half-period. That can be up to (P+1)*(T+1) clocks, so the bench runs windows several tone periods long. A buffer that loads early shows a runt or stretched pulse in the very period of the write. A behavioural model compared on every clock catches it in that period.

// File: rtl/pwm_tone_pkg.sv
package pwm_tone_pkg;

   typedef enum logic [1:0] {
      SEL_PRESCALE = 2'd0,
      SEL_PITCH    = 2'd1,
      SEL_VOLUME   = 2'd2,
      SEL_CONTROL  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic composite;
      logic power;
   } ctl_word_t;

endpackage

// File: rtl/pwm_tone_regs.sv
module pwm_tone_regs
   import pwm_tone_pkg::*;
#(
   parameter int PRE_W  = 9,
   parameter int PIT_W  = 6,
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [PRE_W-1:0]  pre_reg,
   output logic [PIT_W-1:0]  pit_reg,
   output logic [PRE_W-1:0]  vol_reg,
   output ctl_word_t         ctl
);

   reg_sel_e sel;
   assign sel = reg_sel_e'(wr_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_reg <= '0;
         pit_reg <= '0;
         vol_reg <= '0;
         ctl     <= '0;
      end else if (wr_en) begin
         unique case (sel)
            SEL_PRESCALE: pre_reg <= wr_data[PRE_W-1:0];
            SEL_PITCH:    pit_reg <= wr_data[PIT_W-1:0];
            SEL_VOLUME:   vol_reg <= wr_data[PRE_W-1:0];
            SEL_CONTROL:  ctl     <= ctl_word_t'(wr_data[1:0]);
            default:      ;
         endcase
      end
   end

endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         step,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);

   logic [W-1:0] cmp_buf;

   assign wrap = !hold && step && (cnt == cmp_buf);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         cmp_buf <= '0;
      end else if (hold) begin
         cnt     <= '0;
         cmp_buf <= load_val;
      end else if (step) begin
         if (wrap) begin
            cnt     <= '0;
            cmp_buf <= load_val;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   a_r3_cnt_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      !hold |-> cnt <= cmp_buf);

   a_r5_buf_steady : assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !wrap) |=> $stable(cmp_buf));

endmodule

// File: rtl/pwm_latch.sv
module pwm_latch #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold,
   input  logic         period_start,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] vol_load,
   output logic         pwm
);

   logic [W-1:0] vol_buf;
   logic [W:0]   cnt_next;
   logic         hit_end;

   assign cnt_next = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
   assign hit_end  = (cnt_next == {1'b0, vol_buf});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vol_buf <= '0;
         pwm     <= 1'b0;
      end else if (hold) begin
         vol_buf <= vol_load;
         pwm     <= 1'b0;
      end else if (period_start) begin
         vol_buf <= vol_load;
         pwm     <= (vol_load != '0);
      end else if (hit_end) begin
         pwm <= 1'b0;
      end
   end

   a_r7_zero_mute : assert property (@(posedge clk) disable iff (!rst_n)
      (vol_buf == '0) |-> !pwm);

   a_r9_hold_clears : assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !pwm);

   a_r5_vol_steady : assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !period_start) |=> $stable(vol_buf));

endmodule

// File: rtl/pwm_tone_gen.sv
module pwm_tone_gen
   import pwm_tone_pkg::*;
#(
   parameter int PRE_W        = 9,
   parameter int PIT_W        = 6,
   parameter int DATA_W       = 9,
   parameter bit COMPOSITE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tone_o,
   output logic              amp_o
);

   if (PRE_W < 2 || PRE_W > 16) begin : g_bad_pre
      $error("PRE_W out of range");
   end
   if (PIT_W < 1 || PIT_W > 16) begin : g_bad_pit
      $error("PIT_W out of range");
   end
   if (DATA_W < PRE_W || DATA_W < PIT_W) begin : g_bad_data
      $error("DATA_W narrower than a register");
   end

   logic [PRE_W-1:0] pre_reg, vol_reg, pre_cnt;
   logic [PIT_W-1:0] pit_reg, pit_cnt;
   ctl_word_t        ctl;
   logic             hold, pre_wrap, pit_wrap, pwm, tone_q;

   pwm_tone_regs #(.PRE_W(PRE_W), .PIT_W(PIT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pre_reg(pre_reg), .pit_reg(pit_reg),
      .vol_reg(vol_reg), .ctl(ctl)
   );

   assign hold = !ctl.power;

   wrap_counter #(.W(PRE_W)) u_prescale (
      .clk(clk), .rst_n(rst_n), .hold(hold), .step(1'b1),
      .load_val(pre_reg), .cnt(pre_cnt), .wrap(pre_wrap)
   );

   wrap_counter #(.W(PIT_W)) u_pitch (
      .clk(clk), .rst_n(rst_n), .hold(hold), .step(pre_wrap),
      .load_val(pit_reg), .cnt(pit_cnt), .wrap(pit_wrap)
   );

   pwm_latch #(.W(PRE_W)) u_pwm (
      .clk(clk), .rst_n(rst_n), .hold(hold), .period_start(pre_wrap),
      .cnt(pre_cnt), .vol_load(vol_reg), .pwm(pwm)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tone_q <= 1'b0;
      else if (hold)     tone_q <= 1'b0;
      else if (pit_wrap) tone_q <= !tone_q;
   end

   assign amp_o = pwm;

   if (COMPOSITE_EN) begin : g_composite
      assign tone_o = ctl.composite ? (tone_q & pwm) : tone_q;

      a_r8_composite_gated : assert property (@(posedge clk) disable iff (!rst_n)
         (ctl.composite && !amp_o) |-> !tone_o);
   end else begin : g_plain
      assign tone_o = tone_q;
   end

   a_r4_tone_steady : assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.power && !pit_wrap) |=> $stable(tone_q));

   a_r4_pitch_restart : assert property (@(posedge clk) disable iff (!rst_n)
      pit_wrap |=> (pit_cnt == '0));

   a_r9_off_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.power |=> (pre_cnt == '0 && !tone_q));

endmodule

// File: tb/sim_pwm_tone_gen.sv
module sim_pwm_tone_gen;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_sel = 2'd0;
   logic [8:0] wr_data = 9'd0;
   logic       tone_o, amp_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit model_on = 1'b0;

   always #5 clk = ~clk;

   pwm_tone_gen u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .tone_o(tone_o), .amp_o(amp_o)
   );

   // behavioural reference state
   int r_pre, r_pit, r_vol, r_pwr, r_cmp;
   int pc, tc, pb, tb, vb, m_tone, m_amp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_pre = 0; r_pit = 0; r_vol = 0; r_pwr = 0; r_cmp = 0;
         pc = 0; tc = 0; pb = 0; tb = 0; vb = 0; m_tone = 0; m_amp = 0;
      end else begin
         if (r_pwr == 0) begin
            pc = 0; tc = 0; m_tone = 0; m_amp = 0;
            pb = r_pre; tb = r_pit; vb = r_vol;
         end else if (pc == pb) begin
            pc = 0; pb = r_pre; vb = r_vol;
            m_amp = (r_vol != 0) ? 1 : 0;
            if (tc == tb) begin
               tc = 0; tb = r_pit; m_tone = 1 - m_tone;
            end else begin
               tc = tc + 1;
            end
         end else begin
            if (pc + 1 == vb) m_amp = 0;
            pc = pc + 1;
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: r_pre = wr_data;
               2'd1: r_pit = wr_data % 64;
               2'd2: r_vol = wr_data;
               default: begin r_pwr = wr_data % 2; r_cmp = (wr_data / 2) % 2; end
            endcase
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && model_on && !done) begin
         chk("R5 model tone_o", int'(tone_o), (r_cmp != 0) ? (m_tone & m_amp) : m_tone);
         chk("R5 model amp_o", int'(amp_o), m_amp);
      end
   end

   task automatic wr(input logic [1:0] s, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = 9'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(input int n, output int amp_hi, output int tone_hi,
                          output int amp_rise, output int tone_tog);
      logic pa, pt;
      amp_hi = 0; tone_hi = 0; amp_rise = 0; tone_tog = 0;
      pa = amp_o; pt = tone_o;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (amp_o) amp_hi++;
         if (tone_o) tone_hi++;
         if (amp_o && !pa) amp_rise++;
         if (tone_o != pt) tone_tog++;
         pa = amp_o; pt = tone_o;
      end
   endtask

   initial begin
      int ah, th, ar, tt;
      logic prev;
      idle(3);
      chk("R1 tone in reset", int'(tone_o), 0);
      chk("R1 amp in reset", int'(amp_o), 0);
      rst_n = 1'b1;
      model_on = 1'b1;
      idle(2);
      chk("R1 tone after reset", int'(tone_o), 0);
      chk("R1 amp after reset", int'(amp_o), 0);

      // power only, all other settings at reset value zero
      wr(2'd3, 1);
      idle(4);
      measure(20, ah, th, ar, tt);
      chk("R1 zero volume amp high", ah, 0);
      chk("R1 zero settings tone toggles", tt, 20);

      wr(2'd3, 0);
      idle(3);
      measure(30, ah, th, ar, tt);
      chk("R9 off amp high", ah, 0);
      chk("R9 off tone high", th, 0);

      // P=9, T=1, V=3
      wr(2'd0, 9); wr(2'd1, 1); wr(2'd2, 3); wr(2'd3, 1);
      idle(60);
      measure(200, ah, th, ar, tt);
      chk("R6 duty 3/10 amp high", ah, 60);
      chk("R3 amp rises per period", ar, 20);
      chk("R4 tone high half", th, 100);
      chk("R4 tone toggles", tt, 10);

      // upper data bits ignored
      wr(2'd1, 9'h1C1);
      wr(2'd3, 9'h1F1);
      idle(60);
      measure(200, ah, th, ar, tt);
      chk("R2 pitch low bits only", tt, 10);
      chk("R2 control upper bits ignored", th, 100);
      chk("R2 amp unchanged", ah, 60);

      wr(2'd2, 0);
      idle(30);
      measure(100, ah, th, ar, tt);
      chk("R7 zero volume silent", ah, 0);
      wr(2'd2, 10);
      idle(30);
      measure(100, ah, th, ar, tt);
      chk("R7 volume above P full", ah, 100);
      wr(2'd2, 300);
      idle(30);
      measure(100, ah, th, ar, tt);
      chk("R7 large volume full", ah, 100);

      // second pattern P=4, V=2
      wr(2'd0, 4); wr(2'd2, 2);
      idle(40);
      measure(100, ah, th, ar, tt);
      chk("R6 duty 2/5 amp high", ah, 40);
      chk("R3 period five rises", ar, 20);
      chk("R4 tone half period ten", tt, 10);

      // composite mode, P=9, V=5
      wr(2'd0, 9); wr(2'd2, 5); wr(2'd3, 3);
      idle(80);
      measure(200, ah, th, ar, tt);
      chk("R8 composite tone high", th, 50);
      chk("R8 amp still pwm", ah, 100);
      wr(2'd3, 1);
      idle(60);
      measure(200, ah, th, ar, tt);
      chk("R8 plain tone restored", th, 100);

      // mid-period volume write
      prev = amp_o;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (amp_o && !prev) break;
         prev = amp_o;
      end
      idle(2);
      wr(2'd2, 1);
      chk("R5 current pulse kept", int'(amp_o), 1);
      measure(10, ah, th, ar, tt);
      chk("R5 new volume next period", ah, 1);

      // power cycle
      wr(2'd3, 0);
      idle(3);
      measure(20, ah, th, ar, tt);
      chk("R9 off quiet amp", ah, 0);
      chk("R9 off quiet tone", th, 0);
      wr(2'd3, 1);
      measure(9, ah, th, ar, tt);
      chk("R9 first period low", ah, 0);
      idle(40);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual 1 expected 0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule